// File: doc/BRIEF.md
# Prescaled Compare Timer with Clock Select

This block is a 32-bit up-counting timer that sits on a simple synchronous register bus. A configuration word chooses one of eleven tick-enable strobes as the timer's source. An 8-bit prescaler divides that source, and each prescaled tick advances the counter by one while the timer is enabled. All strobes are single-cycle pulses in the system clock domain.

Software loads a compare value. When the counter steps onto that value, the block latches a pending flag and drives a level interrupt. The flag stays set until software writes the clear code to the status register. The counter can also be written directly, and it wraps silently past its maximum.

Top module: `cmp_tick_timer`

## Requirements
- R1: With configuration bit 0 (enable) low, the counter keeps its value whatever strobes arrive. With it high, the counter steps by one on each prescaled tick.
- R2: Configuration bits 31:24 hold the prescale value P. The counter advances once for every P+1 strobes of the selected source.
- R3: Configuration bits 23:20 pick the source. Code 0 maps to strobe 0, 1 to strobe 1, 3 to strobe 2, 4 to strobe 3, 5 to strobe 4, 8 to strobe 5 and 9 to strobe 6. Codes 6, 7 and 10 to 15 select nothing, so the counter never advances. Strobes other than the selected one have no effect.
- R4: With bits 23:20 equal to 2, bits 10:8 choose the source. Sub-code 0 maps to strobe 7, 2 and 3 both map to strobe 8, 4 maps to strobe 9 and 5 maps to strobe 10. Sub-codes 1, 6 and 7 select nothing.
- R5: Configuration bit 11 always reads as 0, and a write to it is discarded.
- R6: Every other configuration bit is stored as written and read back unchanged. For example, 0xDD00000D reads back as 0xDD00000D.
- R7: Any write to the configuration register restarts the prescaler from zero, so the next tick comes exactly P+1 selected strobes after the write.
- R8: Writing offset 0x04 loads the counter. The counter rolls over from 0xFFFFFFFF to 0 with no other effect.
- R9: When a tick moves the counter onto the compare value, status bit 0 and `irq` go high after that same clock edge. Loading the counter directly does not cause a match.
- R10: The pending flag stays set through further counting. It clears only when the status register is written with bits 1:0 equal to 0b11. If a clear and a new match fall in the same cycle, the flag stays set.
- R11: After reset, the compare value, the counter, the configuration and the status all read as zero, and `irq` is low.
- R12: The registers sit at these byte offsets: 0x00 compare, 0x04 counter, 0x08 configuration, 0x14 status (bit 0 only). Reading any other offset returns 0, and writing one changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| src_tick | input | 11 | Candidate source strobes, one bit per source |
| irq | output | 1 | Level interrupt, high while a match is pending |

## Verification
The match-tracking property assumes that software does not rewrite the compare register in the same cycle as a tick. The bench therefore writes registers only in cycles with no strobes, except in the one test that deliberately overlaps a status clear with a match-producing strobe. The wrap and hold properties assume that `src_tick` changes only between clock edges. The bench drives strobes as whole-cycle pulses, and it holds strobes off while it reads registers, so each read sees a settled state.

// File: rtl/ctt_pkg.sv
package ctt_pkg;
    localparam int unsigned SRC_N    = 11;
    localparam int unsigned SRC_IDXW = $clog2(SRC_N);
    localparam int unsigned ADDR_W   = 5;
    localparam int unsigned REG_W    = 32;
    localparam int unsigned PSC_W    = 8;

    localparam logic [ADDR_W-1:0] OFF_CMP  = 5'h00;
    localparam logic [ADDR_W-1:0] OFF_CNT  = 5'h04;
    localparam logic [ADDR_W-1:0] OFF_CFG  = 5'h08;
    localparam logic [ADDR_W-1:0] OFF_STAT = 5'h14;

    localparam logic [REG_W-1:0] CFG_RAZ_MASK = 32'h0000_0800;
    localparam logic [1:0]       CLR_CODE     = 2'b11;

    typedef struct packed {
        logic [REG_W-1:0] cfg;
        logic [REG_W-1:0] cmp;
    } regs_t;

    function automatic logic cfg_enable(input logic [REG_W-1:0] c);
        return c[0];
    endfunction

    function automatic logic [PSC_W-1:0] cfg_prescale(input logic [REG_W-1:0] c);
        return c[31:24];
    endfunction

    function automatic logic [3:0] cfg_source(input logic [REG_W-1:0] c);
        return c[23:20];
    endfunction

    function automatic logic [2:0] cfg_subsource(input logic [REG_W-1:0] c);
        return c[10:8];
    endfunction
endpackage

// File: rtl/ctt_src_mux.sv
module ctt_src_mux
    import ctt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [3:0]       sel_i,
    input  logic [2:0]       sub_i,
    input  logic [SRC_N-1:0] ticks_i,
    output logic             strobe_o
);
    logic [SRC_IDXW-1:0] idx;
    logic                valid;

    always_comb begin
        valid = 1'b1;
        idx   = '0;
        case (sel_i)
            4'd0: idx = SRC_IDXW'(0);
            4'd1: idx = SRC_IDXW'(1);
            4'd3: idx = SRC_IDXW'(2);
            4'd4: idx = SRC_IDXW'(3);
            4'd5: idx = SRC_IDXW'(4);
            4'd8: idx = SRC_IDXW'(5);
            4'd9: idx = SRC_IDXW'(6);
            4'd2: begin
                case (sub_i)
                    3'd0:       idx = SRC_IDXW'(7);
                    3'd2, 3'd3: idx = SRC_IDXW'(8);
                    3'd4:       idx = SRC_IDXW'(9);
                    3'd5:       idx = SRC_IDXW'(10);
                    default:    valid = 1'b0;
                endcase
            end
            default: valid = 1'b0;
        endcase
    end

    assign strobe_o = valid && ticks_i[idx];

    // R3
    dead_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_i == 4'd6 || sel_i == 4'd7 || sel_i >= 4'd10) |-> !strobe_o);

    // R4
    dead_subsource_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_i == 4'd2 && (sub_i == 3'd1 || sub_i >= 3'd6)) |-> !strobe_o);
endmodule

// File: rtl/ctt_prescaler.sv
module ctt_prescaler #(
    parameter int unsigned PW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear_i,
    input  logic          en_i,
    input  logic          strobe_i,
    input  logic [PW-1:0] factor_i,
    output logic          tick_o
);
    typedef struct packed {
        logic [PW-1:0] cnt;
    } psc_t;

    psc_t psc_d, psc_q;

    always_comb begin
        psc_d  = psc_q;
        tick_o = 1'b0;
        if (clear_i) begin
            psc_d.cnt = '0;
        end else if (en_i && strobe_i) begin
            if (psc_q.cnt == factor_i) begin
                tick_o    = 1'b1;
                psc_d.cnt = '0;
            end else begin
                psc_d.cnt = psc_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) psc_q <= '0;
        else        psc_q <= psc_d;
    end

    // R2
    psc_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clear_i |-> psc_q.cnt <= factor_i);

    // R7
    psc_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> psc_q.cnt == '0);
endmodule

// File: rtl/ctt_count_core.sv
module ctt_count_core #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick_i,
    input  logic         cnt_wr_i,
    input  logic [W-1:0] cnt_wdata_i,
    input  logic [W-1:0] cmp_i,
    input  logic         clr_i,
    output logic [W-1:0] cnt_o,
    output logic         pend_o
);
    typedef struct packed {
        logic [W-1:0] cnt;
        logic         pend;
    } core_t;

    core_t core_d, core_q;
    logic [W-1:0] cnt_inc;
    logic         match;

    always_comb begin
        core_d  = core_q;
        cnt_inc = core_q.cnt + 1'b1;
        match   = 1'b0;
        if (cnt_wr_i) begin
            core_d.cnt = cnt_wdata_i;
        end else if (tick_i) begin
            core_d.cnt = cnt_inc;
            match      = (cnt_inc == cmp_i);
        end
        if (match)      core_d.pend = 1'b1;
        else if (clr_i) core_d.pend = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) core_q <= '0;
        else        core_q <= core_d;
    end

    assign cnt_o  = core_q.cnt;
    assign pend_o = core_q.pend;

    // R8
    wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !cnt_wr_i && core_q.cnt == {W{1'b1}}) |=> core_q.cnt == '0);

    // R9
    match_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(core_q.pend) |-> ($past(tick_i) && core_q.cnt == cmp_i));

    // R10
    sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (core_q.pend && !clr_i) |=> core_q.pend);
endmodule

// File: rtl/cmp_tick_timer.sv
module cmp_tick_timer
    import ctt_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_wr,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic [REG_W-1:0]      bus_wdata,
    output logic [REG_W-1:0]      bus_rdata,
    input  logic [SRC_N-1:0]      src_tick,
    output logic                  irq
);
    regs_t st_d, st_q;

    logic             wr_cmp, wr_cnt, wr_cfg, wr_stat;
    logic             clr_req;
    logic             src_strobe;
    logic             tick;
    logic [REG_W-1:0] cnt_val;
    logic             pend;

    always_comb begin
        wr_cmp  = bus_wr && (bus_addr == OFF_CMP);
        wr_cnt  = bus_wr && (bus_addr == OFF_CNT);
        wr_cfg  = bus_wr && (bus_addr == OFF_CFG);
        wr_stat = bus_wr && (bus_addr == OFF_STAT);
        clr_req = wr_stat && (bus_wdata[1:0] == CLR_CODE);

        st_d = st_q;
        if (wr_cmp) st_d.cmp = bus_wdata;
        if (wr_cfg) st_d.cfg = bus_wdata & ~CFG_RAZ_MASK;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    ctt_src_mux i_mux (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel_i    (cfg_source(st_q.cfg)),
        .sub_i    (cfg_subsource(st_q.cfg)),
        .ticks_i  (src_tick),
        .strobe_o (src_strobe)
    );

    ctt_prescaler #(.PW(PSC_W)) i_psc (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear_i  (wr_cfg),
        .en_i     (cfg_enable(st_q.cfg)),
        .strobe_i (src_strobe),
        .factor_i (cfg_prescale(st_q.cfg)),
        .tick_o   (tick)
    );

    ctt_count_core #(.W(REG_W)) i_core (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_i      (tick),
        .cnt_wr_i    (wr_cnt),
        .cnt_wdata_i (bus_wdata),
        .cmp_i       (st_q.cmp),
        .clr_i       (clr_req),
        .cnt_o       (cnt_val),
        .pend_o      (pend)
    );

    always_comb begin
        case (bus_addr)
            OFF_CMP:  bus_rdata = st_q.cmp;
            OFF_CNT:  bus_rdata = cnt_val;
            OFF_CFG:  bus_rdata = st_q.cfg;
            OFF_STAT: bus_rdata = {{(REG_W-1){1'b0}}, pend};
            default:  bus_rdata = '0;
        endcase
    end

    assign irq = pend;

    // R1
    disabled_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.cfg[0] && !wr_cnt) |=> $stable(cnt_val));

    // R5
    raz_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == OFF_CFG) |-> bus_rdata[11] == 1'b0);
endmodule

// File: tb/test_cmp_tick_timer.sv
module test_cmp_tick_timer;
    import ctt_pkg::*;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_wr = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [REG_W-1:0]  bus_wdata = '0;
    logic [REG_W-1:0]  bus_rdata;
    logic [SRC_N-1:0]  src_tick = '0;
    logic              irq;

    always #5 clk = ~clk;

    cmp_tick_timer i_cmp_tick_timer (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_tick(src_tick), .irq(irq)
    );

    typedef struct {
        logic [REG_W-1:0] exp_data;
        logic             exp_irq;
        string            tag;
    } item_t;

    item_t exp_q[$];
    logic  mon_req = 1'b0;
    int    checks = 0;
    int    failures = 0;
    bit    done = 1'b0;

    always @(negedge clk) begin
        if (mon_req && exp_q.size() > 0) begin
            item_t it;
            it = exp_q.pop_front();
            checks++;
            if (bus_rdata !== it.exp_data || irq !== it.exp_irq) begin
                failures++;
                $display("FAIL %s: actual data=%h irq=%b expected data=%h irq=%b",
                         it.tag, bus_rdata, irq, it.exp_data, it.exp_irq);
            end
        end
    end

    task automatic expect_reg(input logic [ADDR_W-1:0] a, input logic [REG_W-1:0] v,
                              input logic i, input string tag);
        item_t it;
        @(posedge clk); #1;
        bus_addr = a;
        it.exp_data = v; it.exp_irq = i; it.tag = tag;
        exp_q.push_back(it);
        mon_req = 1'b1;
        @(posedge clk); #1;
        mon_req = 1'b0;
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [REG_W-1:0] v);
        @(posedge clk); #1;
        bus_wr = 1'b1; bus_addr = a; bus_wdata = v;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic pulse(input logic [SRC_N-1:0] mask, input int n);
        for (int k = 0; k < n; k++) begin
            @(posedge clk); #1;
            src_tick = mask;
            @(posedge clk); #1;
            src_tick = '0;
        end
    endtask

    localparam logic [SRC_N-1:0] S0 = 11'd1;

    initial begin
        #2_000_000;
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R11 reset state
        expect_reg(OFF_CMP,  32'h0, 1'b0, "R11 cmp");
        expect_reg(OFF_CNT,  32'h0, 1'b0, "R11 cnt");
        expect_reg(OFF_CFG,  32'h0, 1'b0, "R11 cfg");
        expect_reg(OFF_STAT, 32'h0, 1'b0, "R11 stat");

        // R6 / R5
        wr(OFF_CFG, 32'hDD00000D);
        expect_reg(OFF_CFG, 32'hDD00000D, 1'b0, "R6 roundtrip");
        wr(OFF_CFG, 32'hFFFFFFFF);
        expect_reg(OFF_CFG, 32'hFFFFF7FF, 1'b0, "R5 bit11 zero");
        wr(OFF_CFG, 32'h0);
        wr(OFF_CNT, 32'h0);

        // R1 counting and hold
        wr(OFF_CFG, 32'h0000_0001);
        pulse(S0, 5);
        expect_reg(OFF_CNT, 32'd5, 1'b0, "R1 counts");
        wr(OFF_CFG, 32'h0);
        pulse(S0, 3);
        expect_reg(OFF_CNT, 32'd5, 1'b0, "R1 hold disabled");

        // R2 prescale 3, source code 1 -> strobe 1
        wr(OFF_CFG, 32'h0310_0001);
        wr(OFF_CNT, 32'h0);
        pulse(11'd1 << 1, 7);
        expect_reg(OFF_CNT, 32'd1, 1'b0, "R2 seven strobes");
        pulse(11'd1 << 1, 1);
        expect_reg(OFF_CNT, 32'd2, 1'b0, "R2 eighth strobe");
        pulse(S0, 4);
        expect_reg(OFF_CNT, 32'd2, 1'b0, "R3 other strobe ignored");

        // R7 prescaler restart
        pulse(11'd1 << 1, 2);
        wr(OFF_CFG, 32'h0310_0001);
        pulse(11'd1 << 1, 3);
        expect_reg(OFF_CNT, 32'd2, 1'b0, "R7 restart no tick");
        pulse(11'd1 << 1, 1);
        expect_reg(OFF_CNT, 32'd3, 1'b0, "R7 tick after P+1");

        // R4 sub-selector 3 -> strobe 8
        wr(OFF_CFG, 32'h0020_0301);
        wr(OFF_CNT, 32'h0);
        pulse(11'd1 << 8, 2);
        expect_reg(OFF_CNT, 32'd2, 1'b0, "R4 sub3 strobe8");
        pulse(11'd1 << 7, 2);
        expect_reg(OFF_CNT, 32'd2, 1'b0, "R4 strobe7 ignored");
        wr(OFF_CFG, 32'h0020_0101);
        pulse('1, 3);
        expect_reg(OFF_CNT, 32'd2, 1'b0, "R4 sub1 no clock");
        wr(OFF_CFG, 32'h0060_0001);
        pulse('1, 3);
        expect_reg(OFF_CNT, 32'd2, 1'b0, "R3 code6 no clock");
        wr(OFF_CFG, 32'h0090_0001);
        pulse(11'd1 << 6, 1);
        expect_reg(OFF_CNT, 32'd3, 1'b0, "R3 code9 strobe6");

        // R12 unmapped offsets
        wr(5'h10, 32'h1234_5678);
        expect_reg(5'h0C, 32'h0, 1'b0, "R12 unmapped read");
        expect_reg(OFF_CNT, 32'd3, 1'b0, "R12 unmapped write ignored");

        // R9 / R10 compare
        wr(OFF_CFG, 32'h0000_0001);
        wr(OFF_CMP, 32'd10);
        wr(OFF_CNT, 32'd8);
        pulse(S0, 1);
        expect_reg(OFF_STAT, 32'd0, 1'b0, "R9 no match yet");
        pulse(S0, 1);
        expect_reg(OFF_STAT, 32'd1, 1'b1, "R9 match");
        pulse(S0, 3);
        expect_reg(OFF_STAT, 32'd1, 1'b1, "R10 sticky");
        wr(OFF_STAT, 32'h1);
        expect_reg(OFF_STAT, 32'd1, 1'b1, "R10 partial clear ignored");
        wr(OFF_STAT, 32'h3);
        expect_reg(OFF_STAT, 32'd0, 1'b0, "R10 cleared");
        wr(OFF_CNT, 32'd10);
        expect_reg(OFF_STAT, 32'd0, 1'b0, "R9 load no match");

        // R10 clear and match together
        wr(OFF_CNT, 32'd9);
        @(posedge clk); #1;
        bus_wr = 1'b1; bus_addr = OFF_STAT; bus_wdata = 32'h3; src_tick = S0;
        @(posedge clk); #1;
        bus_wr = 1'b0; src_tick = '0;
        expect_reg(OFF_STAT, 32'd1, 1'b1, "R10 match wins");

        // R8 wrap
        wr(OFF_STAT, 32'h3);
        wr(OFF_CMP, 32'd5);
        wr(OFF_CNT, 32'hFFFF_FFFE);
        pulse(S0, 2);
        expect_reg(OFF_CNT, 32'h0, 1'b0, "R8 wrap");
        expect_reg(OFF_STAT, 32'h0, 1'b0, "R8 wrap no side effect");

        repeat (2) @(posedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule